// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execute core of a simple processor: a bank of eight general registers, an operand selector, a combined arithmetic, logic and shift unit, and a write-back selector. A 17-bit control word arrives each clock. In that cycle the block reads two registers, optionally swaps the second operand for a constant, computes a result, picks either that result or an external data word, and writes the pick into a destination register at the next rising edge.

The two operand buses are visible at the ports as an address output (first operand) and a data output (second operand after the constant selector). Four status flags (zero, negative, carry, overflow) describe the current result in the same cycle. A sequencer or test harness drives the control word. Instruction fetch, memory and pipelining live elsewhere.

Top module: `ctrl_datapath`

## Requirements
- R1: The control word `ctrl_word[16:0]` is split as: destination address [16:14], first read address [13:11], second read address [10:8], operand-B select [7], function code [6:2], write-back select [1], write enable [0]. Example: destination 1, reads 2 and 3, B from registers, function 00101, result write-back, write on, gives R1 = R2 + R3 + 1.
- R2: `addr_out` shows the register named by the first read address in the same cycle, with no clock edge in between.
- R3: `data_out` shows the register named by the second read address when operand-B select is 0, and `const_in` when it is 1; the function unit's B operand is that same value.
- R4: With write enable 1, the selected write-back value lands in the destination register at the next rising edge; with write enable 0, no register changes.
- R5: Write-back select 0 writes the function result; 1 writes `data_in`.
- R6: A read of the register that is being written in the same cycle returns its old contents.
- R7: Function codes with bits [4:3] = 00 are arithmetic: F = A + Y + code[0] modulo 2^WIDTH, where code[2:1] picks Y: 00 zero, 01 all ones, 10 B, 11 bitwise NOT of B.
- R8: Function codes with bits [4:3] = 01 are logic, chosen by code[1:0]: 00 A AND B, 01 A OR B, 10 A XOR B, 11 NOT A; code[2] has no effect.
- R9: Function codes with bit 4 = 1 are shifts of B, chosen by code[1:0]: 00 B unchanged, 01 right by one with zero fill, 10 left by one with zero fill, 11 rotate right by one; code[3:2] have no effect.
- R10: Z is 1 exactly when F is all zeros, N equals the top bit of F, C is the carry out of the arithmetic sum and V its two's-complement overflow; C and V are 0 for logic and shift codes.
- R11: An asynchronous active-low reset clears all eight registers to zero immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 17 | Control word for this cycle |
| const_in | input | WIDTH | Constant offered as operand B |
| data_in | input | WIDTH | External write-back data |
| addr_out | output | WIDTH | First operand bus |
| data_out | output | WIDTH | Second operand bus after constant select |
| flag_v | output | 1 | Signed overflow of arithmetic result |
| flag_c | output | 1 | Carry out of arithmetic result |
| flag_n | output | 1 | Top bit of the result |
| flag_z | output | 1 | Result is all zeros |

## Verification
Because both reads are combinational, a register holding a wrong value appears on `addr_out` or `data_out` in the very cycle it is addressed, and a lost or misdirected write shows one edge later on the next read of the destination. A wrong function decode or flag computation is visible in the same cycle on the flags, and one edge later in a register when the result is written back and read. Corner cases covered include signed overflow both ways, carry out with a zero result, register 0 and register 7, a write and read of the same register in one cycle, and reset arriving between edges.

// File: rtl/dp_pkg.sv
package dp_pkg;

    localparam int ADDR_W = 3;
    localparam int FS_W   = 5;
    localparam int CW_W   = 3 * ADDR_W + FS_W + 3;

    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src_a;
        logic [ADDR_W-1:0] src_b;
        logic              b_const;
        logic [FS_W-1:0]   func;
        logic              wb_ext;
        logic              wr_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'd0,
        UNIT_LOGIC = 2'd1,
        UNIT_SHIFT = 2'd2
    } unit_e;

    typedef enum logic [1:0] {
        Y_ZERO = 2'd0,
        Y_ONES = 2'd1,
        Y_B    = 2'd2,
        Y_NOTB = 2'd3
    } ysel_e;

    typedef enum logic [1:0] {
        LOG_AND  = 2'd0,
        LOG_OR   = 2'd1,
        LOG_XOR  = 2'd2,
        LOG_NOTA = 2'd3
    } logop_e;

    typedef enum logic [1:0] {
        SH_PASS = 2'd0,
        SH_SRL  = 2'd1,
        SH_SLL  = 2'd2,
        SH_ROR  = 2'd3
    } shop_e;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [WIDTH-1:0]  rd_a_data,
    output logic [WIDTH-1:0]  rd_b_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] regs [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        logic load;
        assign load = wr_en && (wr_addr == ADDR_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (load) begin
                regs[g] <= wr_data;
            end
        end
    end

    // Reads are combinational from the stored state: no write bypass.
    assign rd_a_data = regs[rd_a_addr];
    assign rd_b_data = regs[rd_b_addr];

endmodule

// File: rtl/dp_arith.sv
module dp_arith
    import dp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  ysel_e            ysel,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y;
    logic [WIDTH:0]   wide;

    always_comb begin
        unique case (ysel)
            Y_ZERO:  y = '0;
            Y_ONES:  y = '1;
            Y_B:     y = b;
            Y_NOTB:  y = ~b;
            default: y = '0;
        endcase
    end

    assign wide = {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    assign sum  = wide[WIDTH-1:0];
    assign cout = wide[WIDTH];
    assign ovf  = (a[MSB] == y[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/dp_shifter.sv
module dp_shifter
    import dp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] b,
    input  shop_e            op,
    output logic [WIDTH-1:0] res
);
    logic [WIDTH-1:0] srl_v;
    logic [WIDTH-1:0] sll_v;
    logic [WIDTH-1:0] ror_v;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_top
            assign srl_v[i] = 1'b0;
            assign ror_v[i] = b[0];
        end else begin : g_mid
            assign srl_v[i] = b[i+1];
            assign ror_v[i] = b[i+1];
        end
        if (i == 0) begin : g_low
            assign sll_v[i] = 1'b0;
        end else begin : g_up
            assign sll_v[i] = b[i-1];
        end
    end

    always_comb begin
        unique case (op)
            SH_PASS: res = b;
            SH_SRL:  res = srl_v;
            SH_SLL:  res = sll_v;
            SH_ROR:  res = ror_v;
            default: res = b;
        endcase
    end

endmodule

// File: rtl/dp_func_unit.sv
module dp_func_unit
    import dp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [FS_W-1:0]  func,
    output logic [WIDTH-1:0] f,
    output logic             flag_v,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_z
);
    unit_e            unit;
    logic [WIDTH-1:0] ar_sum;
    logic             ar_cout;
    logic             ar_ovf;
    logic [WIDTH-1:0] lg_res;
    logic [WIDTH-1:0] sh_res;

    always_comb begin
        if (func[4])      unit = UNIT_SHIFT;
        else if (func[3]) unit = UNIT_LOGIC;
        else              unit = UNIT_ARITH;
    end

    dp_arith #(.WIDTH(WIDTH)) u_arith (
        .a    (a),
        .b    (b),
        .ysel (ysel_e'(func[2:1])),
        .cin  (func[0]),
        .sum  (ar_sum),
        .cout (ar_cout),
        .ovf  (ar_ovf)
    );

    dp_shifter #(.WIDTH(WIDTH)) u_shift (
        .b   (b),
        .op  (shop_e'(func[1:0])),
        .res (sh_res)
    );

    always_comb begin
        unique case (logop_e'(func[1:0]))
            LOG_AND:  lg_res = a & b;
            LOG_OR:   lg_res = a | b;
            LOG_XOR:  lg_res = a ^ b;
            LOG_NOTA: lg_res = ~a;
            default:  lg_res = a & b;
        endcase
    end

    always_comb begin
        f      = ar_sum;
        flag_c = 1'b0;
        flag_v = 1'b0;
        unique case (unit)
            UNIT_ARITH: begin
                f      = ar_sum;
                flag_c = ar_cout;
                flag_v = ar_ovf;
            end
            UNIT_LOGIC: f = lg_res;
            UNIT_SHIFT: f = sh_res;
            default:    f = ar_sum;
        endcase
    end

    assign flag_n = f[WIDTH-1];
    assign flag_z = (f == '0);

endmodule

// File: rtl/ctrl_datapath.sv
module ctrl_datapath
    import dp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [16:0]      ctrl_word,
    input  logic [WIDTH-1:0] const_in,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] addr_out,
    output logic [WIDTH-1:0] data_out,
    output logic             flag_v,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_z
);
    ctrl_t            cw;
    logic [WIDTH-1:0] bus_a;
    logic [WIDTH-1:0] reg_b;
    logic [WIDTH-1:0] bus_b;
    logic [WIDTH-1:0] fu_out;
    logic [WIDTH-1:0] wr_data;

    assign cw = ctrl_t'(ctrl_word[CW_W-1:0]);

    dp_regfile #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cw.wr_en),
        .wr_addr   (cw.dst),
        .wr_data   (wr_data),
        .rd_a_addr (cw.src_a),
        .rd_b_addr (cw.src_b),
        .rd_a_data (bus_a),
        .rd_b_data (reg_b)
    );

    assign bus_b = cw.b_const ? const_in : reg_b;

    dp_func_unit #(.WIDTH(WIDTH)) u_fu (
        .a      (bus_a),
        .b      (bus_b),
        .func   (cw.func),
        .f      (fu_out),
        .flag_v (flag_v),
        .flag_c (flag_c),
        .flag_n (flag_n),
        .flag_z (flag_z)
    );

    assign wr_data  = cw.wb_ext ? data_in : fu_out;
    assign addr_out = bus_a;
    assign data_out = bus_b;

endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [16:0]      cw,
    input logic [WIDTH-1:0] addr_out,
    input logic [WIDTH-1:0] data_out,
    input logic [WIDTH-1:0] wr_data,
    input logic             flag_v,
    input logic             flag_c,
    input logic             flag_n,
    input logic             flag_z
);
    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cw[0]) ##1 (cw[13:11] == $past(cw[13:11])) |-> $stable(addr_out));

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw[0] ##1 (cw[13:11] == $past(cw[16:14])) |-> (addr_out == $past(wr_data)));

    // R2
    same_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cw[13:11] == cw[10:8]) && !cw[7]) |-> (addr_out == data_out));

    // R10
    zero_not_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n);

    // R10
    no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw[6] || cw[5]) |-> (!flag_c && !flag_v));

endmodule

bind ctrl_datapath dp_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cw       (ctrl_word),
    .addr_out (addr_out),
    .data_out (data_out),
    .wr_data  (wr_data),
    .flag_v   (flag_v),
    .flag_c   (flag_c),
    .flag_n   (flag_n),
    .flag_z   (flag_z)
);

// File: tb/test_ctrl_datapath.sv
module test_ctrl_datapath;
    localparam int W = 16;
    localparam int NV = 26;

    typedef struct packed {
        logic [16:0]  cw;
        logic [W-1:0] k;
        logic [W-1:0] din;
        logic [W-1:0] ea;
        logic [W-1:0] ed;
        logic [3:0]   ef;   // {V,C,N,Z}
        logic [3:0]   req;
    } vec_t;

    // cw = {dst, srcA, srcB, bconst, func, wb_ext, wr_en}
    localparam vec_t TBL [NV] = '{
        // R5 load R1 from data_in
        {{3'd1,3'd0,3'd0,1'b0,5'b00000,1'b1,1'b1}, 16'h0000, 16'h1234, 16'h0000, 16'h0000, 4'b0001, 4'd5},
        // R5 load R2, R2 read of R1
        {{3'd2,3'd1,3'd0,1'b0,5'b00000,1'b1,1'b1}, 16'h0000, 16'h7FFF, 16'h1234, 16'h0000, 4'b0000, 4'd5},
        // R7 R10 positive overflow on A+B
        {{3'd3,3'd2,3'd1,1'b0,5'b00100,1'b1,1'b1}, 16'h0000, 16'h0001, 16'h7FFF, 16'h1234, 4'b1010, 4'd7},
        // R1 encoded R1 = R2 + R3 + 1
        {{3'd1,3'd2,3'd3,1'b0,5'b00101,1'b0,1'b1}, 16'h0000, 16'h0000, 16'h7FFF, 16'h0001, 4'b1010, 4'd1},
        // R4 result landed next edge
        {{3'd0,3'd1,3'd2,1'b0,5'b00000,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h8001, 16'h7FFF, 4'b0010, 4'd4},
        // R3 constant as B, negative overflow with carry
        {{3'd0,3'd1,3'd0,1'b1,5'b00100,1'b0,1'b0}, 16'h8000, 16'h0000, 16'h8001, 16'h8000, 4'b1100, 4'd3},
        // R7 subtract equal values
        {{3'd0,3'd2,3'd2,1'b0,5'b00111,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h7FFF, 16'h7FFF, 4'b0101, 4'd7},
        // R7 decrement zero
        {{3'd0,3'd0,3'd0,1'b0,5'b00010,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'b0010, 4'd7},
        // R8 AND
        {{3'd0,3'd1,3'd2,1'b0,5'b01000,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h8001, 16'h7FFF, 4'b0000, 4'd8},
        // R8 OR
        {{3'd0,3'd1,3'd2,1'b0,5'b01001,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h8001, 16'h7FFF, 4'b0010, 4'd8},
        // R8 XOR
        {{3'd0,3'd1,3'd2,1'b0,5'b01010,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h8001, 16'h7FFF, 4'b0010, 4'd8},
        // R8 NOT A
        {{3'd0,3'd1,3'd2,1'b0,5'b01011,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h8001, 16'h7FFF, 4'b0000, 4'd8},
        // R8 bit 2 ignored
        {{3'd0,3'd1,3'd2,1'b0,5'b01100,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h8001, 16'h7FFF, 4'b0000, 4'd8},
        // R9 pass B
        {{3'd0,3'd2,3'd1,1'b0,5'b10000,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h7FFF, 16'h8001, 4'b0010, 4'd9},
        // R9 shift right
        {{3'd0,3'd2,3'd1,1'b0,5'b10001,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h7FFF, 16'h8001, 4'b0000, 4'd9},
        // R9 shift left
        {{3'd0,3'd2,3'd1,1'b0,5'b10010,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h7FFF, 16'h8001, 4'b0000, 4'd9},
        // R9 rotate right
        {{3'd0,3'd2,3'd1,1'b0,5'b10011,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h7FFF, 16'h8001, 4'b0010, 4'd9},
        // R9 bits 3:2 ignored
        {{3'd0,3'd2,3'd1,1'b0,5'b11101,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h7FFF, 16'h8001, 4'b0000, 4'd9},
        // R4 write disabled
        {{3'd1,3'd1,3'd1,1'b0,5'b00000,1'b1,1'b0}, 16'h0000, 16'hAAAA, 16'h8001, 16'h8001, 4'b0010, 4'd4},
        // R4 R1 unchanged, R4 gets increment
        {{3'd4,3'd1,3'd1,1'b0,5'b00001,1'b0,1'b1}, 16'h0000, 16'h0000, 16'h8001, 16'h8001, 4'b0010, 4'd4},
        // R6 read and write R4 same cycle
        {{3'd4,3'd4,3'd4,1'b0,5'b00000,1'b1,1'b1}, 16'h0000, 16'h0F0F, 16'h8002, 16'h8002, 4'b0010, 4'd6},
        // R6 new value next cycle
        {{3'd0,3'd4,3'd0,1'b0,5'b00000,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h0F0F, 16'h0000, 4'b0000, 4'd6},
        // R4 top register write
        {{3'd7,3'd7,3'd0,1'b0,5'b00000,1'b1,1'b1}, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 4'b0001, 4'd4},
        // R10 carry out with zero result
        {{3'd0,3'd7,3'd7,1'b0,5'b00001,1'b0,1'b0}, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 4'b0101, 4'd10},
        // R2 register 0 write
        {{3'd0,3'd0,3'd0,1'b0,5'b00000,1'b1,1'b1}, 16'h0000, 16'h5555, 16'h0000, 16'h0000, 4'b0001, 4'd2},
        // R2 register 0 read
        {{3'd0,3'd0,3'd7,1'b0,5'b00000,1'b0,1'b0}, 16'h0000, 16'h0000, 16'h5555, 16'hFFFF, 4'b0000, 4'd2}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [16:0]  ctrl_word = '0;
    logic [W-1:0] const_in = '0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] addr_out;
    logic [W-1:0] data_out;
    logic         flag_v, flag_c, flag_n, flag_z;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctrl_datapath #(.WIDTH(W)) i_ctrl_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .const_in  (const_in),
        .data_in   (data_in),
        .addr_out  (addr_out),
        .data_out  (data_out),
        .flag_v    (flag_v),
        .flag_c    (flag_c),
        .flag_n    (flag_n),
        .flag_z    (flag_z)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [16:0] cw, input logic [W-1:0] k, input logic [W-1:0] din);
        @(negedge clk);
        ctrl_word = cw;
        const_in  = k;
        data_in   = din;
        #2;
    endtask

    initial begin
        // R11 reset state: all registers read zero
        ctrl_word = {3'd0,3'd3,3'd5,1'b0,5'b00000,1'b0,1'b1};
        data_in   = 16'hFFFF;
        #7;
        check("R11 reset addr_out", addr_out, 16'h0000);
        check("R11 reset data_out", data_out, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].cw, TBL[i].k, TBL[i].din);
            check($sformatf("R%0d row %0d addr_out", TBL[i].req, i), addr_out, TBL[i].ea);
            check($sformatf("R%0d row %0d data_out", TBL[i].req, i), data_out, TBL[i].ed);
            check($sformatf("R%0d row %0d flags VCNZ", TBL[i].req, i),
                  {12'h000, flag_v, flag_c, flag_n, flag_z}, {12'h000, TBL[i].ef});
        end

        // R11 asynchronous clear between edges: R7 held FFFF
        apply({3'd0,3'd7,3'd1,1'b0,5'b00000,1'b0,1'b0}, 16'h0000, 16'h0000);
        check("R11 before reset addr_out", addr_out, 16'hFFFF);
        rst_n = 1'b0;
        #0.5;
        check("R11 async clear addr_out", addr_out, 16'h0000);
        check("R11 async clear data_out", data_out, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        apply({3'd0,3'd4,3'd0,1'b0,5'b00000,1'b0,1'b0}, 16'h0000, 16'h0000);
        check("R11 register 4 cleared", addr_out, 16'h0000);

        // R3 constant on data_out with B register nonzero afterwards
        apply({3'd2,3'd0,3'd0,1'b0,5'b00000,1'b1,1'b1}, 16'h0000, 16'h00F0);
        apply({3'd0,3'd0,3'd2,1'b1,5'b01001,1'b0,1'b0}, 16'h0F00, 16'h0000);
        check("R3 constant replaces B", data_out, 16'h0F00);
        apply({3'd0,3'd0,3'd2,1'b0,5'b01001,1'b0,1'b0}, 16'h0F00, 16'h0000);
        check("R3 register B selected", data_out, 16'h00F0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule